// File: doc/BRIEF.md
# I2C Bus Timing Field Search Engine

This block works out the five timing fields an I2C master needs: a prescaler, a data setup delay, a data hold delay, and the SCL low and high counts. It starts from the kernel clock period in nanoseconds, the wanted SCL period, the bus rise and fall times, the analog and digital filter settings and a speed class. The search is sequential and exhaustive, and runs in two phases.

The first phase visits every prescaler. For each one it keeps the first setup/hold delay pair that meets the class windows, and stores that pair in a small register file with one valid bit per entry. The second phase visits every stored prescaler, sweeps the low and high counts and keeps the pair whose full SCL period is nearest the target. The sweep skips any part of the space that provably cannot win.

Software or a boot sequencer raises `start` once. It then waits for the one-cycle `done` pulse and reads the fields together with a found flag.

Top module: `i2c_tsearch`

## Requirements
- R1: After reset, busy, done and found are 0, and every timing field output is 0.
- R2: A start pulse while idle begins a search. Busy stays high until the result is ready. Done is high for exactly one cycle, with busy low in that cycle. A start pulse while busy has no effect on the result or the duration of the run. The caller holds the configuration inputs steady while busy.
- R3: The hold window is [max(0, fall − afmin − (dnf+3)·tclk), max(0, validmax − rise − afmax − (dnf+4)·tclk)]. The setup floor is rise + setupmin. With the analog filter on, afmin is 50 ns and afmax is 260 ns; with it off, both are 0.
- R4: For prescaler p in 0..15, the engine takes the smallest setup code s in 0..15 with (s+1)(p+1)·tclk ≥ setup floor. It pairs it with the smallest hold code a in 0..15 whose delay (a(p+1)+1)·tclk lies in the hold window. A prescaler with no such pair is left out of the second phase.
- R5: With step = (p+1)·tclk and sync = afmin + dnf·tclk + 2·tclk, low time = (L+1)·step + sync and high time = (H+1)·step + sync. A low count is usable only if low time ≥ lowmin and tclk < ((L+1)·step + 2·tclk)/4, using integer division.
- R6: A pair is accepted only if all of these hold: total = low + high + rise + fall lies within [permin, permax]; high time ≥ highmin; tclk < high time.
- R7: The engine returns the accepted pair with the smallest |total − target|. An error must be strictly below the current best to replace it, and the best starts at the target period itself. Candidates are ranked in ascending prescaler, then low count, then high count order, so the earliest of equal errors wins.
- R8: If the first phase finds no prescaler, or the second phase accepts no pair, found is 0 and all field outputs are 0.
- R9: Speed class 0 uses lowmin 4700, highmin 4000, setupmin 250, validmax 3450 and period window [8333, 125000]. Class 1 uses 1300, 600, 100, 900 and [2083, 3125]. Class 2 uses 500, 260, 50, 450 and [833, 1250]. Class 3 returns no solution. All values are in ns.
- R10: Found and the field outputs keep their values from one done pulse until the next accepted start, whatever the configuration inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a search (used only when idle) |
| tclk_i | input | TCW | Kernel clock period, ns |
| target_i | input | 32 | Wanted SCL period, ns |
| rise_i | input | TCW | Bus rise time, ns |
| fall_i | input | TCW | Bus fall time, ns |
| anf_i | input | 1 | Analog filter enabled |
| dnf_i | input | 5 | Digital filter length, 0..16 |
| class_i | input | 2 | Speed class code |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| found_o | output | 1 | A field set was found |
| presc_o | output | 4 | Prescaler code |
| setup_o | output | 4 | Setup delay code |
| hold_o | output | 4 | Hold delay code |
| low_o | output | 8 | SCL low count |
| high_o | output | 8 | SCL high count |

## Verification
The assertions assume that the period, target, edge-time, filter and class inputs do not change while busy. The register-file and error-tracking properties only make sense under that assumption, and one property states it explicitly. The stimulus applies each configuration on a falling edge before the start pulse and changes it only after done. The idle-hold case deliberately changes the configuration while the engine is idle. All periods are kept small enough that no intermediate product exceeds 32 bits. The stray start pulse is sent with unchanged configuration, so the stability assumption still holds during the busy window.

// File: rtl/i2c_tsearch_pkg.sv
package i2c_tsearch_pkg;
    localparam int TW = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP_SCAN,
        ST_HOLD_SCAN,
        ST_PICK,
        ST_PAIR_SCAN,
        ST_FINISH
    } state_e;

    typedef struct packed {
        logic [TW-1:0] low_min;
        logic [TW-1:0] high_min;
        logic [TW-1:0] setup_min;
        logic [TW-1:0] valid_max;
        logic [TW-1:0] per_min;
        logic [TW-1:0] per_max;
    } class_lim_t;

    function automatic class_lim_t class_limits(input logic [1:0] cls);
        class_lim_t r;
        r = '0;
        case (cls)
            2'd0: begin
                r.low_min = 32'd4700;  r.high_min = 32'd4000;
                r.setup_min = 32'd250; r.valid_max = 32'd3450;
                r.per_min = 32'd8333;  r.per_max = 32'd125000;
            end
            2'd1: begin
                r.low_min = 32'd1300;  r.high_min = 32'd600;
                r.setup_min = 32'd100; r.valid_max = 32'd900;
                r.per_min = 32'd2083;  r.per_max = 32'd3125;
            end
            2'd2: begin
                r.low_min = 32'd500;   r.high_min = 32'd260;
                r.setup_min = 32'd50;  r.valid_max = 32'd450;
                r.per_min = 32'd833;   r.per_max = 32'd1250;
            end
            default: r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/i2c_tsearch_bounds.sv
module i2c_tsearch_bounds
    import i2c_tsearch_pkg::*;
#(
    parameter int TCW = 16
) (
    input  logic [TCW-1:0] tclk_i,
    input  logic [TCW-1:0] rise_i,
    input  logic [TCW-1:0] fall_i,
    input  logic           anf_i,
    input  logic [4:0]     dnf_i,
    input  class_lim_t     lim_i,
    output logic [TW-1:0]  hold_lo_o,
    output logic [TW-1:0]  hold_hi_o,
    output logic [TW-1:0]  setup_floor_o,
    output logic [TW-1:0]  sync_o
);
    logic signed [TW:0] s_tclk, s_rise, s_fall, s_dnf, s_afmin, s_afmax, s_vmax;
    logic signed [TW:0] lo_raw, hi_raw;

    always_comb begin
        s_tclk  = (TW+1)'(tclk_i);
        s_rise  = (TW+1)'(rise_i);
        s_fall  = (TW+1)'(fall_i);
        s_dnf   = (TW+1)'(dnf_i);
        s_vmax  = (TW+1)'(lim_i.valid_max);
        s_afmin = anf_i ? 33'sd50  : 33'sd0;
        s_afmax = anf_i ? 33'sd260 : 33'sd0;
        lo_raw  = s_fall - s_afmin - (s_dnf + 33'sd3) * s_tclk;
        hi_raw  = s_vmax - s_rise - s_afmax - (s_dnf + 33'sd4) * s_tclk;
        hold_lo_o     = lo_raw[TW] ? '0 : lo_raw[TW-1:0];
        hold_hi_o     = hi_raw[TW] ? '0 : hi_raw[TW-1:0];
        setup_floor_o = TW'(rise_i) + lim_i.setup_min;
        sync_o        = TW'(s_afmin[TW-1:0]) + TW'(dnf_i) * TW'(tclk_i) + (TW'(tclk_i) << 1);
    end
endmodule

// File: rtl/i2c_tsearch_cands.sv
module i2c_tsearch_cands #(
    parameter int NP = 16,
    parameter int DW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  wr_i,
    input  logic [$clog2(NP)-1:0] wr_addr_i,
    input  logic [DW-1:0]         wr_s_i,
    input  logic [DW-1:0]         wr_a_i,
    input  logic [$clog2(NP)-1:0] rd_addr_i,
    output logic                  rd_vld_o,
    output logic [DW-1:0]         rd_s_o,
    output logic [DW-1:0]         rd_a_o,
    output logic                  any_vld_o
);
    localparam int AW = $clog2(NP);

    logic [NP-1:0] vld_w;
    logic [DW-1:0] s_w [NP];
    logic [DW-1:0] a_w [NP];

    for (genvar i = 0; i < NP; i++) begin : g_ent
        logic          vld_q;
        logic [DW-1:0] s_q, a_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                s_q   <= '0;
                a_q   <= '0;
            end else if (clr_i) begin
                vld_q <= 1'b0;
            end else if (wr_i && wr_addr_i == AW'(i)) begin
                vld_q <= 1'b1;
                s_q   <= wr_s_i;
                a_q   <= wr_a_i;
            end
        end
        assign vld_w[i] = vld_q;
        assign s_w[i]   = s_q;
        assign a_w[i]   = a_q;
    end

    assign rd_vld_o  = vld_w[rd_addr_i];
    assign rd_s_o    = s_w[rd_addr_i];
    assign rd_a_o    = a_w[rd_addr_i];
    assign any_vld_o = |vld_w;

    // R4
    cand_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !clr_i) |=> vld_w[$past(wr_addr_i)]);
    // R4
    clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> !wr_i);
endmodule

// File: rtl/i2c_tsearch_pair.sv
module i2c_tsearch_pair
    import i2c_tsearch_pkg::*;
(
    input  logic [TW-1:0] tclk_i,
    input  logic [TW-1:0] lprod_i,
    input  logic [TW-1:0] hprod_i,
    input  logic [TW-1:0] sync_i,
    input  logic [TW-1:0] edges_i,
    input  logic [TW-1:0] target_i,
    input  class_lim_t    lim_i,
    output logic          low_ok_o,
    output logic          accept_o,
    output logic          over_o,
    output logic          above_o,
    output logic [TW-1:0] err_o
);
    logic [TW-1:0] low_t, high_t, total;

    always_comb begin
        low_t    = lprod_i + sync_i;
        high_t   = hprod_i + sync_i;
        total    = low_t + high_t + edges_i;
        low_ok_o = (low_t >= lim_i.low_min) &&
                   (tclk_i < ((lprod_i + (tclk_i << 1)) >> 2));
        over_o   = total > lim_i.per_max;
        above_o  = total > target_i;
        accept_o = low_ok_o && !over_o && (total >= lim_i.per_min) &&
                   (high_t >= lim_i.high_min) && (tclk_i < high_t);
        err_o    = above_o ? total - target_i : target_i - total;
    end
endmodule

// File: rtl/i2c_tsearch.sv
module i2c_tsearch
    import i2c_tsearch_pkg::*;
#(
    parameter int TCW = 16,
    parameter int NP  = 16,
    parameter int ND  = 16,
    parameter int NS  = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [TCW-1:0]        tclk_i,
    input  logic [31:0]           target_i,
    input  logic [TCW-1:0]        rise_i,
    input  logic [TCW-1:0]        fall_i,
    input  logic                  anf_i,
    input  logic [4:0]            dnf_i,
    input  logic [1:0]            class_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic                  found_o,
    output logic [$clog2(NP)-1:0] presc_o,
    output logic [$clog2(ND)-1:0] setup_o,
    output logic [$clog2(ND)-1:0] hold_o,
    output logic [$clog2(NS)-1:0] low_o,
    output logic [$clog2(NS)-1:0] high_o
);
    localparam int PW = $clog2(NP);
    localparam int DW = $clog2(ND);
    localparam int SW = $clog2(NS);

    typedef struct packed {
        state_e        state;
        logic [PW-1:0] p;
        logic [SW-1:0] l;
        logic [SW-1:0] h;
        logic [PW-1:0] best_p;
        logic [SW-1:0] best_l;
        logic [SW-1:0] best_h;
        logic [TW-1:0] best_err;
        logic          hit;
        logic          done;
        logic          found;
        logic [PW-1:0] o_p;
        logic [DW-1:0] o_s;
        logic [DW-1:0] o_a;
        logic [SW-1:0] o_lo;
        logic [SW-1:0] o_hi;
    } regs_t;

    regs_t r_q, r_d;

    class_lim_t    lim;
    logic [TW-1:0] hold_lo, hold_hi, setup_floor, sync_t;
    logic [TW-1:0] tclk_w, step, lprod, hprod, holdv, edges;
    logic          clr, wr, rd_vld, any_vld;
    logic [DW-1:0] rd_s, rd_a;
    logic [PW-1:0] rd_addr;
    logic          low_ok, accept, over, above;
    logic [TW-1:0] err;

    assign lim    = class_limits(class_i);
    assign tclk_w = TW'(tclk_i);
    assign edges  = TW'(rise_i) + TW'(fall_i);
    assign step   = (TW'(r_q.p) + 1) * tclk_w;
    assign lprod  = (TW'(r_q.l) + 1) * step;
    assign hprod  = (TW'(r_q.h) + 1) * step;
    assign holdv  = (TW'(r_q.h) * (TW'(r_q.p) + 1) + 1) * tclk_w;
    assign rd_addr = (r_q.state == ST_FINISH) ? r_q.best_p : r_q.p;

    i2c_tsearch_bounds #(.TCW(TCW)) bounds_i (
        .tclk_i(tclk_i), .rise_i(rise_i), .fall_i(fall_i), .anf_i(anf_i),
        .dnf_i(dnf_i), .lim_i(lim), .hold_lo_o(hold_lo), .hold_hi_o(hold_hi),
        .setup_floor_o(setup_floor), .sync_o(sync_t)
    );

    i2c_tsearch_cands #(.NP(NP), .DW(DW)) cands_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .wr_i(wr), .wr_addr_i(r_q.p),
        .wr_s_i(r_q.l[DW-1:0]), .wr_a_i(r_q.h[DW-1:0]), .rd_addr_i(rd_addr),
        .rd_vld_o(rd_vld), .rd_s_o(rd_s), .rd_a_o(rd_a), .any_vld_o(any_vld)
    );

    i2c_tsearch_pair pair_i (
        .tclk_i(tclk_w), .lprod_i(lprod), .hprod_i(hprod), .sync_i(sync_t),
        .edges_i(edges), .target_i(target_i), .lim_i(lim), .low_ok_o(low_ok),
        .accept_o(accept), .over_o(over), .above_o(above), .err_o(err)
    );

    always_comb begin
        logic go_p1, go_l2, go_p2;
        r_d = r_q;
        r_d.done = 1'b0;
        clr = 1'b0;
        wr  = 1'b0;
        go_p1 = 1'b0;
        go_l2 = 1'b0;
        go_p2 = 1'b0;
        case (r_q.state)
            ST_IDLE: if (start_i) begin
                clr = 1'b1;
                r_d.p = '0; r_d.l = '0; r_d.h = '0;
                r_d.best_p = '0; r_d.best_l = '0; r_d.best_h = '0;
                r_d.best_err = target_i;
                r_d.hit = 1'b0;
                r_d.state = (class_i == 2'd3) ? ST_FINISH : ST_SETUP_SCAN;
            end
            ST_SETUP_SCAN: begin
                if (lprod >= setup_floor) begin
                    r_d.state = ST_HOLD_SCAN;
                    r_d.h = '0;
                end else if (r_q.l == SW'(ND-1)) go_p1 = 1'b1;
                else r_d.l = r_q.l + 1'b1;
            end
            ST_HOLD_SCAN: begin
                if (holdv >= hold_lo && holdv <= hold_hi) begin
                    wr = 1'b1;
                    go_p1 = 1'b1;
                end else if (r_q.h == SW'(ND-1)) go_p1 = 1'b1;
                else r_d.h = r_q.h + 1'b1;
            end
            ST_PICK: begin
                if (!any_vld) r_d.state = ST_FINISH;
                else if (rd_vld) begin
                    r_d.state = ST_PAIR_SCAN;
                    r_d.l = '0;
                    r_d.h = '0;
                end else go_p2 = 1'b1;
            end
            ST_PAIR_SCAN: begin
                if (accept && err < r_q.best_err) begin
                    r_d.best_err = err;
                    r_d.best_p = r_q.p; r_d.best_l = r_q.l; r_d.best_h = r_q.h;
                    r_d.hit = 1'b1;
                end
                if (over && r_q.h == '0) go_p2 = 1'b1;
                else if (!low_ok || over || (accept && above) || r_q.h == SW'(NS-1)) go_l2 = 1'b1;
                else r_d.h = r_q.h + 1'b1;
            end
            ST_FINISH: begin
                r_d.done  = 1'b1;
                r_d.found = r_q.hit;
                r_d.o_p   = r_q.hit ? r_q.best_p : '0;
                r_d.o_s   = r_q.hit ? rd_s : '0;
                r_d.o_a   = r_q.hit ? rd_a : '0;
                r_d.o_lo  = r_q.hit ? r_q.best_l : '0;
                r_d.o_hi  = r_q.hit ? r_q.best_h : '0;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (go_p1) begin
            if (r_q.p == PW'(NP-1)) begin
                r_d.state = ST_PICK;
                r_d.p = '0;
            end else begin
                r_d.p = r_q.p + 1'b1;
                r_d.l = '0;
                r_d.state = ST_SETUP_SCAN;
            end
        end
        if (go_l2) begin
            if (r_q.l == SW'(NS-1)) go_p2 = 1'b1;
            else begin
                r_d.l = r_q.l + 1'b1;
                r_d.h = '0;
            end
        end
        if (go_p2) begin
            if (r_q.p == PW'(NP-1)) r_d.state = ST_FINISH;
            else begin
                r_d.p = r_q.p + 1'b1;
                r_d.state = ST_PICK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy_o  = r_q.state != ST_IDLE;
    assign done_o  = r_q.done;
    assign found_o = r_q.found;
    assign presc_o = r_q.o_p;
    assign setup_o = r_q.o_s;
    assign hold_o  = r_q.o_a;
    assign low_o   = r_q.o_lo;
    assign high_o  = r_q.o_hi;

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R2
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(tclk_i) && $stable(target_i) &&
        $stable(rise_i) && $stable(fall_i) && $stable(anf_i) && $stable(dnf_i) && $stable(class_i)));
    // R7
    err_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> r_q.best_err <= $past(r_q.best_err));
    // R8
    nosol_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !found_o) |-> (presc_o == '0 && setup_o == '0 && hold_o == '0 &&
        low_o == '0 && high_o == '0));
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o) && !$past(start_i)) |->
        $stable({found_o, presc_o, setup_o, hold_o, low_o, high_o}));
endmodule

// File: tb/i2c_tsearch_tb.sv
module i2c_tsearch_tb_top;
    typedef struct packed {
        logic [15:0] tclk;
        logic [31:0] target;
        logic [15:0] rise;
        logic [15:0] fall;
        logic        anf;
        logic [4:0]  dnf;
        logic [1:0]  cls;
        logic        exp_found;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{16'd250, 32'd10000, 16'd25,  16'd10,  1'b1, 5'd0,  2'd0, 1'b1},
        '{16'd20,  32'd2500,  16'd100, 16'd50,  1'b1, 5'd2,  2'd1, 1'b1},
        '{16'd10,  32'd1000,  16'd50,  16'd20,  1'b0, 5'd0,  2'd2, 1'b1},
        '{16'd200, 32'd1000,  16'd25,  16'd10,  1'b1, 5'd0,  2'd2, 1'b0},
        '{16'd20,  32'd400,   16'd20,  16'd10,  1'b0, 5'd16, 2'd2, 1'b0},
        '{16'd20,  32'd2500,  16'd100, 16'd50,  1'b1, 5'd2,  2'd3, 1'b0},
        '{16'd10,  32'd2500,  16'd100, 16'd300, 1'b0, 5'd0,  2'd1, 1'b1}
    };
    localparam int WD_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] tclk_i = '0, rise_i = '0, fall_i = '0;
    logic [31:0] target_i = '0;
    logic        anf_i = 1'b0;
    logic [4:0]  dnf_i = '0;
    logic [1:0]  class_i = '0;
    logic        busy_o, done_o, found_o;
    logic [3:0]  presc_o, setup_o, hold_o;
    logic [7:0]  low_o, high_o;

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit wd_hit = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT) wd_hit <= 1'b1;
    end

    i2c_tsearch dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tclk_i(tclk_i),
        .target_i(target_i), .rise_i(rise_i), .fall_i(fall_i), .anf_i(anf_i),
        .dnf_i(dnf_i), .class_i(class_i), .busy_o(busy_o), .done_o(done_o),
        .found_o(found_o), .presc_o(presc_o), .setup_o(setup_o), .hold_o(hold_o),
        .low_o(low_o), .high_o(high_o)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Independent brute-force reference built from the requirement text.
    function automatic void model(input vec_t v, output bit f, output int rp, output int rs,
                                  output int ra, output int rlo, output int rhi);
        int lowmin, highmin, sumin, vmax, cmin, cmax;
        int t, afl, afh, hlo, hhi, sfl, sync, best, pre, tl, th, ts, e, dn;
        bit cv [16];
        int cs [16];
        int ca [16];
        f = 0; rp = 0; rs = 0; ra = 0; rlo = 0; rhi = 0;
        case (v.cls)
            2'd0: begin lowmin = 4700; highmin = 4000; sumin = 250; vmax = 3450;
                        cmin = 1000000000 / 120000; cmax = 1000000000 / 8000; end
            2'd1: begin lowmin = 1300; highmin = 600; sumin = 100; vmax = 900;
                        cmin = 1000000000 / 480000; cmax = 1000000000 / 320000; end
            2'd2: begin lowmin = 500; highmin = 260; sumin = 50; vmax = 450;
                        cmin = 1000000000 / 1200000; cmax = 1000000000 / 800000; end
            default: return;
        endcase
        t = int'(v.tclk); dn = int'(v.dnf);
        afl = v.anf ? 50 : 0;
        afh = v.anf ? 260 : 0;
        hlo = int'(v.fall) - afl - (dn + 3) * t;
        hhi = vmax - int'(v.rise) - afh - (dn + 4) * t;
        if (hlo < 0) hlo = 0;
        if (hhi < 0) hhi = 0;
        sfl = int'(v.rise) + sumin;
        for (int p = 0; p < 16; p++) begin
            cv[p] = 0; cs[p] = 0; ca[p] = 0;
            for (int l = 0; l < 16 && !cv[p]; l++) begin
                if ((l + 1) * (p + 1) * t < sfl) continue;
                for (int a = 0; a < 16 && !cv[p]; a++) begin
                    int sd;
                    sd = (a * (p + 1) + 1) * t;
                    if (sd >= hlo && sd <= hhi) begin cv[p] = 1; cs[p] = l; ca[p] = a; end
                end
            end
        end
        sync = afl + dn * t + 2 * t;
        best = int'(v.target);
        for (int p = 0; p < 16; p++) begin
            if (!cv[p]) continue;
            pre = (p + 1) * t;
            for (int l = 0; l < 256; l++) begin
                tl = (l + 1) * pre + sync;
                if (tl < lowmin || t >= (tl - afl - dn * t) / 4) continue;
                for (int h = 0; h < 256; h++) begin
                    th = (h + 1) * pre + sync;
                    ts = tl + th + int'(v.rise) + int'(v.fall);
                    if (ts >= cmin && ts <= cmax && th >= highmin && t < th) begin
                        e = (ts > int'(v.target)) ? ts - int'(v.target) : int'(v.target) - ts;
                        if (e < best) begin
                            best = e; f = 1; rp = p; rs = cs[p]; ra = ca[p]; rlo = l; rhi = h;
                        end
                    end
                end
            end
        end
    endfunction

    task automatic apply(input vec_t v);
        tclk_i = v.tclk; target_i = v.target; rise_i = v.rise; fall_i = v.fall;
        anf_i = v.anf; dnf_i = v.dnf; class_i = v.cls;
    endtask

    task automatic run_vec(input vec_t v, input bit poke, output int cyc);
        @(negedge clk);
        apply(v);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        chk("R2", "busy after start", longint'(busy_o), 1);
        while (!done_o && !wd_hit) begin
            start_i = (poke && cyc == 5) ? 1'b1 : 1'b0;
            @(negedge clk);
            start_i = 1'b0;
            cyc++;
        end
        if (!wd_hit) chk("R2", "busy low with done", longint'(busy_o), 0);
    endtask

    task automatic check_result(input vec_t v, input int idx);
        bit f;
        int rp, rs, ra, rlo, rhi;
        model(v, f, rp, rs, ra, rlo, rhi);
        chk("R8", $sformatf("v%0d found", idx), longint'(found_o), longint'(f));
        chk("R8", $sformatf("v%0d table found", idx), longint'(found_o), longint'(v.exp_found));
        chk("R4", $sformatf("v%0d presc", idx), longint'(presc_o), longint'(rp));
        chk("R3", $sformatf("v%0d setup", idx), longint'(setup_o), longint'(rs));
        chk("R3", $sformatf("v%0d hold", idx), longint'(hold_o), longint'(ra));
        chk("R5,R7", $sformatf("v%0d low", idx), longint'(low_o), longint'(rlo));
        chk("R6,R7", $sformatf("v%0d high", idx), longint'(high_o), longint'(rhi));
    endtask

    initial begin
        int cyc_a, cyc_b;
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1", "busy", longint'(busy_o), 0);
        chk("R1", "done", longint'(done_o), 0);
        chk("R1", "found", longint'(found_o), 0);
        chk("R1", "fields", longint'({presc_o, setup_o, hold_o, low_o, high_o}), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            int cyc;
            if (wd_hit) break;
            run_vec(VECS[i], 1'b0, cyc);
            if (!wd_hit) check_result(VECS[i], i);
            if (i == 1) cyc_a = cyc;
        end

        if (!wd_hit) begin
            // R9 reserved class code gives no solution
            run_vec(VECS[5], 1'b0, cyc_b);
            chk("R9", "class 3 found", longint'(found_o), 0);
            // R4 prescaler 0 cannot meet the raised hold floor of 270 ns
            run_vec(VECS[6], 1'b0, cyc_b);
            chk("R4", "presc 0 excluded", longint'(presc_o != 0), 1);
            // R3 chosen hold delay respects the floor
            chk("R3", "hold above floor",
                longint'((int'(hold_o) * (int'(presc_o) + 1) + 1) * 10 >= 270), 1);
        end

        if (!wd_hit) begin
            // R2 stray start while busy: same result, same duration
            run_vec(VECS[1], 1'b1, cyc_b);
            check_result(VECS[1], 1);
            chk("R2", "run length with stray start", longint'(cyc_b), longint'(cyc_a));
            @(negedge clk);
            chk("R2", "done one cycle", longint'(done_o), 0);
        end

        if (!wd_hit) begin
            // R10 outputs hold while idle inputs change
            apply(VECS[3]);
            repeat (20) @(negedge clk);
            check_result(VECS[1], 1);
            chk("R10", "still idle", longint'(busy_o), 0);
        end

        if (wd_hit) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule